// File: doc/BRIEF.md
# Ping-Pong Buffer Descriptor Tracker

This block keeps the bookkeeping for one DMA channel that works from two buffer descriptor slots used in turn. Software hands it buffers through an enqueue request carrying an address and a byte size. The block checks the size against the rules of the channel kind selected on its configuration inputs. It then writes the descriptor (address, size minus one, ready bit) into the slot pointed to by its fill index, and the fill index moves to the other slot.

The DMA engine reports a finished buffer with a completion event. The slot under the service index loses its ready bit, the service index moves on, and a request counter advances. A software service strobe retires one outstanding completion per strobe. This lowers the fill level and raises the completed-buffer count, which software later reduces with a detach request. A ready output tells software whether another buffer may be enqueued. Size, overflow and underflow faults are reported as one-cycle error pulses.

Top module: `pp_desc_tracker`

## Requirements
- R1: After synchronous reset, ready is 1, the completed count is 0, both slot ready bits are 0, both indexes are 0 and no error pulse is high.
- R2: An accepted enqueue writes the slot under the fill index with the address, the size minus one and a set ready bit, and toggles the fill index; all of this is visible one cycle after the request.
- R3: An enqueue with a legal size while the fill level is 2 raises err_overflow for one cycle and leaves the slots, the fill index and ready unchanged.
- R4: ready is 1 exactly when fewer than 2 buffers are held (enqueued and not yet retired by a service strobe).
- R5: A completion event clears the ready bit of the slot under the service index, keeps its address and size, and toggles the service index.
- R6: A service strobe while completions are outstanding lowers the fill level by one and raises the completed count by one; with no outstanding completion it changes nothing and raises no error.
- R7: A service strobe that finds an outstanding completion while the fill level is 0 raises err_underflow and consumes that completion without changing the completed count.
- R8: A detach of N buffers with N greater than the completed count raises err_underflow and leaves the count unchanged; otherwise N is subtracted from the count.
- R9: The channel kind is 2'b00 control, 2'b01 asynchronous, 2'b10 isochronous, 2'b11 synchronous. For every kind a size of 0 or above 8192 is rejected with err_size and nothing changes; control and asynchronous accept any size from 1 to 8192.
- R10: An isochronous size is accepted only if it is a multiple of the packet length and holds at least two packets.
- R11: A synchronous size is accepted only if it is a non-zero multiple of the bytes-per-frame value shifted left by the frame-count setting.
- R12: The completed count is 8 bits wide and wraps from 255 to 0.
- R13: A request whose size is illegal reports err_size only, even when the fill level is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_kind | input | 2 | Channel kind (encoding in R9) |
| cfg_pkt_len | input | 14 | Isochronous packet length in bytes |
| cfg_bpf | input | 14 | Synchronous bytes per frame |
| cfg_fcnt | input | 3 | Frame-count shift for synchronous sizes |
| enq_valid | input | 1 | Enqueue request strobe |
| enq_addr | input | 32 | Buffer address |
| enq_size | input | 14 | Buffer size in bytes |
| cmpl_valid | input | 1 | Completion event from the DMA engine |
| svc_valid | input | 1 | Software service strobe |
| det_valid | input | 1 | Detach request strobe |
| det_count | input | 8 | Number of buffers to detach |
| ready | output | 1 | Another buffer may be enqueued |
| fill_idx | output | 1 | Slot the next enqueue will write |
| svc_idx | output | 1 | Slot the next completion will clear |
| done_count | output | 8 | Completed buffers not yet detached |
| slot_addr | output | 64 | Slot addresses, slot 0 in bits 31:0 |
| slot_bd | output | 26 | Slot size-minus-one fields, slot 0 in bits 12:0 |
| slot_rdy | output | 2 | Slot ready bits, slot 0 in bit 0 |
| err_size | output | 1 | Size rule violation pulse |
| err_overflow | output | 1 | Enqueue while full pulse |
| err_underflow | output | 1 | Service or detach underflow pulse |

## Verification
The hardest situation to reach is the service underflow of R7. It needs a completion to be counted while no buffer is held, and a well-behaved DMA engine never produces one. The stimulus drives completion events on an empty channel, twice so that the service index comes back in step with the fill index, then strobes service twice to see both underflow pulses and a third time to see that nothing remains outstanding. The 8-bit wrap of R12 is reached by cycling 256 buffers through enqueue, completion and service without detaching any.

// File: rtl/pp_desc_pkg.sv
package pp_desc_pkg;

  localparam int ADDR_W = 32;
  localparam int BD_W   = 13;
  localparam int SIZE_W = BD_W + 1;
  localparam int FC_W   = 3;

  typedef enum logic [1:0] {
    KIND_CTRL  = 2'b00,
    KIND_ASYNC = 2'b01,
    KIND_ISOC  = 2'b10,
    KIND_SYNC  = 2'b11
  } chan_kind_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [BD_W-1:0]   bd;
    logic              rdy;
  } slot_t;

endpackage

// File: rtl/pp_size_check.sv
module pp_size_check
  import pp_desc_pkg::*;
#(
  parameter int SZ_W = SIZE_W,
  parameter int FS_W = FC_W,
  parameter int BDW  = BD_W
) (
  input  chan_kind_e       kind,
  input  logic [SZ_W-1:0]  size,
  input  logic [SZ_W-1:0]  pkt_len,
  input  logic [SZ_W-1:0]  bpf,
  input  logic [FS_W-1:0]  fcnt,
  output logic             ok
);

  localparam int UNIT_W = SZ_W + (1 << FS_W) - 1;
  localparam logic [SZ_W-1:0] MAX_SZ = SZ_W'(1) << BDW;

  logic [UNIT_W-1:0] unit_w;
  logic [UNIT_W-1:0] unit_div;
  logic [UNIT_W-1:0] size_u;
  logic [SZ_W-1:0]   pkt_div;
  logic [SZ_W:0]     two_pkt;
  logic              range_ok;
  logic              isoc_ok;
  logic              sync_ok;

  always_comb begin
    unit_w   = UNIT_W'(bpf) << fcnt;
    unit_div = (unit_w == '0) ? UNIT_W'(1) : unit_w;
    size_u   = UNIT_W'(size);
    pkt_div  = (pkt_len == '0) ? SZ_W'(1) : pkt_len;
    two_pkt  = {pkt_len, 1'b0};
    range_ok = (size != '0) && (size <= MAX_SZ);
    isoc_ok  = (pkt_len != '0) && ((size % pkt_div) == '0) &&
               ({1'b0, size} >= two_pkt);
    sync_ok  = (unit_w != '0) && ((size_u % unit_div) == '0) &&
               (size_u >= unit_w);
    unique case (kind)
      KIND_ISOC: ok = range_ok && isoc_ok;
      KIND_SYNC: ok = range_ok && sync_ok;
      default:   ok = range_ok;
    endcase
  end

endmodule

// File: rtl/pp_slot_bank.sv
module pp_slot_bank
  import pp_desc_pkg::*;
#(
  parameter int NSLOT = 2,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        wr_idx,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BD_W-1:0]         wr_bd,
  input  logic                    clr_en,
  input  logic [IDX_W-1:0]        clr_idx,
  output slot_t [NSLOT-1:0]       slots_o
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    slot_t slot_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(s))) begin
        slot_q.addr <= wr_addr;
        slot_q.bd   <= wr_bd;
        slot_q.rdy  <= 1'b1;
      end else if (clr_en && (clr_idx == IDX_W'(s))) begin
        slot_q.rdy  <= 1'b0;
      end
    end

    assign slots_o[s] = slot_q;
  end

endmodule

// File: rtl/pp_fill_ctrl.sv
module pp_fill_ctrl #(
  parameter int CNT_W = 8,
  parameter int NSLOT = 2,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int LVL_W = $clog2(NSLOT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enq_valid,
  input  logic             size_ok,
  input  logic             cmpl_valid,
  input  logic             svc_valid,
  input  logic             det_valid,
  input  logic [CNT_W-1:0] det_count,
  output logic             enq_accept,
  output logic [IDX_W-1:0] fill_idx,
  output logic [IDX_W-1:0] svc_idx,
  output logic             ready,
  output logic [CNT_W-1:0] done_count,
  output logic             err_size,
  output logic             err_overflow,
  output logic             err_underflow
);

  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(NSLOT);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NSLOT - 1);

  logic [LVL_W-1:0] level_q;
  logic [CNT_W-1:0] req_q;
  logic [CNT_W-1:0] svc_q;
  logic [CNT_W-1:0] done_q;
  logic [IDX_W-1:0] fill_q;
  logic [IDX_W-1:0] sidx_q;

  logic room;
  logic pending;
  logic svc_take;
  logic svc_dec;
  logic svc_unf;
  logic det_bad;
  logic det_ok;

  always_comb begin
    room       = level_q < LVL_FULL;
    enq_accept = enq_valid && size_ok && room;
    pending    = req_q != svc_q;
    svc_take   = svc_valid && pending;
    svc_dec    = svc_take && (level_q != '0);
    svc_unf    = svc_take && (level_q == '0);
    det_bad    = det_valid && (det_count > done_q);
    det_ok     = det_valid && !det_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q       <= '0;
      req_q         <= '0;
      svc_q         <= '0;
      done_q        <= '0;
      fill_q        <= '0;
      sidx_q        <= '0;
      err_size      <= 1'b0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      level_q <= level_q + LVL_W'(enq_accept) - LVL_W'(svc_dec);
      req_q   <= req_q + CNT_W'(cmpl_valid);
      svc_q   <= svc_q + CNT_W'(svc_take);
      done_q  <= done_q + CNT_W'(svc_dec) - (det_ok ? det_count : '0);
      if (enq_accept) begin
        fill_q <= (fill_q == IDX_LAST) ? '0 : fill_q + IDX_W'(1);
      end
      if (cmpl_valid) begin
        sidx_q <= (sidx_q == IDX_LAST) ? '0 : sidx_q + IDX_W'(1);
      end
      err_size      <= enq_valid && !size_ok;
      err_overflow  <= enq_valid && size_ok && !room;
      err_underflow <= svc_unf || det_bad;
    end
  end

  assign fill_idx   = fill_q;
  assign svc_idx    = sidx_q;
  assign ready      = level_q < LVL_FULL;
  assign done_count = done_q;

endmodule

// File: rtl/pp_desc_tracker.sv
module pp_desc_tracker
  import pp_desc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NSLOT = 2,
  localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                cfg_kind,
  input  logic [SIZE_W-1:0]         cfg_pkt_len,
  input  logic [SIZE_W-1:0]         cfg_bpf,
  input  logic [FC_W-1:0]           cfg_fcnt,
  input  logic                      enq_valid,
  input  logic [ADDR_W-1:0]         enq_addr,
  input  logic [SIZE_W-1:0]         enq_size,
  input  logic                      cmpl_valid,
  input  logic                      svc_valid,
  input  logic                      det_valid,
  input  logic [CNT_W-1:0]          det_count,
  output logic                      ready,
  output logic [IDX_W-1:0]          fill_idx,
  output logic [IDX_W-1:0]          svc_idx,
  output logic [CNT_W-1:0]          done_count,
  output logic [NSLOT*ADDR_W-1:0]   slot_addr,
  output logic [NSLOT*BD_W-1:0]     slot_bd,
  output logic [NSLOT-1:0]          slot_rdy,
  output logic                      err_size,
  output logic                      err_overflow,
  output logic                      err_underflow
);

  logic                size_ok;
  logic                enq_accept;
  logic [BD_W-1:0]     wr_bd;
  slot_t [NSLOT-1:0]   slots;

  pp_size_check #(
    .SZ_W (SIZE_W),
    .FS_W (FC_W),
    .BDW  (BD_W)
  ) size_chk_i (
    .kind    (chan_kind_e'(cfg_kind)),
    .size    (enq_size),
    .pkt_len (cfg_pkt_len),
    .bpf     (cfg_bpf),
    .fcnt    (cfg_fcnt),
    .ok      (size_ok)
  );

  pp_fill_ctrl #(
    .CNT_W (CNT_W),
    .NSLOT (NSLOT)
  ) ctrl_i (
    .clk           (clk),
    .rst           (rst),
    .enq_valid     (enq_valid),
    .size_ok       (size_ok),
    .cmpl_valid    (cmpl_valid),
    .svc_valid     (svc_valid),
    .det_valid     (det_valid),
    .det_count     (det_count),
    .enq_accept    (enq_accept),
    .fill_idx      (fill_idx),
    .svc_idx       (svc_idx),
    .ready         (ready),
    .done_count    (done_count),
    .err_size      (err_size),
    .err_overflow  (err_overflow),
    .err_underflow (err_underflow)
  );

  assign wr_bd = BD_W'(enq_size - SIZE_W'(1));

  pp_slot_bank #(
    .NSLOT (NSLOT)
  ) bank_i (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (enq_accept),
    .wr_idx  (fill_idx),
    .wr_addr (enq_addr),
    .wr_bd   (wr_bd),
    .clr_en  (cmpl_valid),
    .clr_idx (svc_idx),
    .slots_o (slots)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_out
    assign slot_addr[s*ADDR_W +: ADDR_W] = slots[s].addr;
    assign slot_bd[s*BD_W +: BD_W]       = slots[s].bd;
    assign slot_rdy[s]                   = slots[s].rdy;
  end

endmodule

// File: rtl/pp_desc_tracker_chk.sv
module pp_desc_tracker_chk #(
  parameter int CNT_W  = 8,
  parameter int NSLOT  = 2,
  parameter int IDX_W  = 1,
  parameter int AW_ALL = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              enq_valid,
  input logic              size_ok,
  input logic              cmpl_valid,
  input logic              svc_valid,
  input logic              det_valid,
  input logic [CNT_W-1:0]  det_count,
  input logic              ready,
  input logic [IDX_W-1:0]  fill_idx,
  input logic [IDX_W-1:0]  svc_idx,
  input logic [CNT_W-1:0]  done_count,
  input logic [AW_ALL-1:0] slot_addr,
  input logic              err_size,
  input logic              err_overflow,
  input logic              err_underflow
);

  assert_fill_toggle_R2: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && size_ok && ready) |=> (fill_idx != $past(fill_idx)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && size_ok && !ready) |=>
      (err_overflow && $stable(slot_addr) && $stable(fill_idx)));

  assert_svc_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    cmpl_valid |=> (svc_idx != $past(svc_idx)));

  assert_done_step_R6: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && !det_valid) |=>
      (CNT_W'(done_count - $past(done_count)) <= CNT_W'(1)));

  assert_detach_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    (det_valid && (det_count > done_count)) |=>
      (err_underflow && (done_count == $past(done_count))));

  assert_size_reject_R9: assert property (@(posedge clk) disable iff (rst)
    (enq_valid && !size_ok) |=> (err_size && $stable(fill_idx)));

  assert_err_exclusive_R13: assert property (@(posedge clk) disable iff (rst)
    $onehot0({err_size, err_overflow}));

endmodule

bind pp_desc_tracker pp_desc_tracker_chk #(
  .CNT_W  (CNT_W),
  .NSLOT  (NSLOT),
  .IDX_W  (IDX_W),
  .AW_ALL (NSLOT * pp_desc_pkg::ADDR_W)
) chk_i (
  .clk           (clk),
  .rst           (rst),
  .enq_valid     (enq_valid),
  .size_ok       (size_ok),
  .cmpl_valid    (cmpl_valid),
  .svc_valid     (svc_valid),
  .det_valid     (det_valid),
  .det_count     (det_count),
  .ready         (ready),
  .fill_idx      (fill_idx),
  .svc_idx       (svc_idx),
  .done_count    (done_count),
  .slot_addr     (slot_addr),
  .err_size      (err_size),
  .err_overflow  (err_overflow),
  .err_underflow (err_underflow)
);

// File: tb/pp_desc_tracker_tb_top.sv
`timescale 1ns/1ps
module pp_desc_tracker_tb_top;
  import pp_desc_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_kind = 2'b00;
  logic [13:0] cfg_pkt_len = '0;
  logic [13:0] cfg_bpf = '0;
  logic [2:0]  cfg_fcnt = '0;
  logic        enq_valid = 1'b0;
  logic [31:0] enq_addr = '0;
  logic [13:0] enq_size = '0;
  logic        cmpl_valid = 1'b0;
  logic        svc_valid = 1'b0;
  logic        det_valid = 1'b0;
  logic [7:0]  det_count = '0;
  logic        ready;
  logic [0:0]  fill_idx;
  logic [0:0]  svc_idx;
  logic [7:0]  done_count;
  logic [63:0] slot_addr;
  logic [25:0] slot_bd;
  logic [1:0]  slot_rdy;
  logic        err_size;
  logic        err_overflow;
  logic        err_underflow;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pp_desc_tracker dut_i (
    .clk(clk), .rst(rst), .cfg_kind(cfg_kind), .cfg_pkt_len(cfg_pkt_len),
    .cfg_bpf(cfg_bpf), .cfg_fcnt(cfg_fcnt), .enq_valid(enq_valid),
    .enq_addr(enq_addr), .enq_size(enq_size), .cmpl_valid(cmpl_valid),
    .svc_valid(svc_valid), .det_valid(det_valid), .det_count(det_count),
    .ready(ready), .fill_idx(fill_idx), .svc_idx(svc_idx),
    .done_count(done_count), .slot_addr(slot_addr), .slot_bd(slot_bd),
    .slot_rdy(slot_rdy), .err_size(err_size), .err_overflow(err_overflow),
    .err_underflow(err_underflow)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_err(input string req, input logic s, input logic o, input logic u);
    chk(req, "err_size", 64'(err_size), 64'(s));
    chk(req, "err_overflow", 64'(err_overflow), 64'(o));
    chk(req, "err_underflow", 64'(err_underflow), 64'(u));
  endtask

  task automatic do_enq(input logic [31:0] a, input int sz);
    enq_addr = a; enq_size = 14'(sz); enq_valid = 1'b1;
    @(posedge clk); #1;
    enq_valid = 1'b0;
  endtask

  task automatic do_cmpl();
    cmpl_valid = 1'b1;
    @(posedge clk); #1;
    cmpl_valid = 1'b0;
  endtask

  task automatic do_svc();
    svc_valid = 1'b1;
    @(posedge clk); #1;
    svc_valid = 1'b0;
  endtask

  task automatic do_det(input int n);
    det_count = 8'(n); det_valid = 1'b1;
    @(posedge clk); #1;
    det_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      do_cmpl();
      do_svc();
    end
    do_det(n);
  endtask

  task automatic t_reset();
    chk("R1", "ready", 64'(ready), 64'(1));
    chk("R1", "done_count", 64'(done_count), 64'(0));
    chk("R1", "slot_rdy", 64'(slot_rdy), 64'(0));
    chk("R1", "fill_idx", 64'(fill_idx), 64'(0));
    chk("R1", "svc_idx", 64'(svc_idx), 64'(0));
    chk_err("R1", 0, 0, 0);
  endtask

  task automatic t_fill();
    cfg_kind = 2'b00;
    do_enq(32'hA000_0000, 100);
    chk("R2", "slot0 addr", 64'(slot_addr[31:0]), 64'hA000_0000);
    chk("R2", "slot0 bd", 64'(slot_bd[12:0]), 64'd99);
    chk("R2", "slot_rdy", 64'(slot_rdy), 64'b01);
    chk("R2", "fill_idx", 64'(fill_idx), 64'(1));
    chk("R4", "ready one held", 64'(ready), 64'(1));
    chk_err("R2", 0, 0, 0);
    do_enq(32'hB111_0000, 8192);
    chk("R2", "slot1 addr", 64'(slot_addr[63:32]), 64'hB111_0000);
    chk("R2", "slot1 bd", 64'(slot_bd[25:13]), 64'h1FFF);
    chk("R2", "fill_idx back", 64'(fill_idx), 64'(0));
    chk("R4", "ready two held", 64'(ready), 64'(0));
    do_enq(32'hC222_0000, 50);
    chk_err("R3", 0, 1, 0);
    chk("R3", "slot0 addr kept", 64'(slot_addr[31:0]), 64'hA000_0000);
    chk("R3", "fill_idx kept", 64'(fill_idx), 64'(0));
    chk("R3", "ready", 64'(ready), 64'(0));
  endtask

  task automatic t_complete();
    do_cmpl();
    chk("R5", "slot_rdy after cmpl", 64'(slot_rdy), 64'b10);
    chk("R5", "svc_idx", 64'(svc_idx), 64'(1));
    chk("R5", "slot0 addr kept", 64'(slot_addr[31:0]), 64'hA000_0000);
    chk("R4", "ready before service", 64'(ready), 64'(0));
    do_svc();
    chk("R6", "done after svc", 64'(done_count), 64'(1));
    chk("R4", "ready after svc", 64'(ready), 64'(1));
    chk_err("R6", 0, 0, 0);
    do_svc();
    chk("R6", "idle svc done", 64'(done_count), 64'(1));
    chk_err("R6", 0, 0, 0);
    do_cmpl();
    chk("R5", "slot_rdy both clear", 64'(slot_rdy), 64'b00);
    chk("R5", "svc_idx back", 64'(svc_idx), 64'(0));
    do_svc();
    chk("R6", "done two", 64'(done_count), 64'(2));
  endtask

  task automatic t_detach();
    do_det(3);
    chk_err("R8", 0, 0, 1);
    chk("R8", "done kept", 64'(done_count), 64'(2));
    do_det(2);
    chk_err("R8", 0, 0, 0);
    chk("R8", "done after detach", 64'(done_count), 64'(0));
  endtask

  task automatic t_underflow();
    do_cmpl();
    do_cmpl();
    chk("R7", "svc_idx realigned", 64'(svc_idx), 64'(fill_idx));
    do_svc();
    chk_err("R7", 0, 0, 1);
    chk("R7", "done unchanged", 64'(done_count), 64'(0));
    chk("R7", "ready", 64'(ready), 64'(1));
    do_svc();
    chk_err("R7", 0, 0, 1);
    do_svc();
    chk_err("R6", 0, 0, 0);
    chk("R6", "done after idle svc", 64'(done_count), 64'(0));
  endtask

  task automatic t_size_generic();
    logic [0:0] f0;
    f0 = fill_idx;
    cfg_kind = 2'b00;
    do_enq(32'h1, 0);
    chk_err("R9", 1, 0, 0);
    chk("R9", "fill kept zero size", 64'(fill_idx), 64'(f0));
    do_enq(32'h2, 8193);
    chk_err("R9", 1, 0, 0);
    chk("R9", "slot_rdy none", 64'(slot_rdy), 64'b00);
    cfg_kind = 2'b01;
    do_enq(32'h3, 1);
    chk_err("R9", 0, 0, 0);
    chk("R9", "async size 1 bd", 64'(slot_bd[12:0]), 64'd0);
    chk("R9", "async slot rdy", 64'(slot_rdy), 64'b01);
    drain(1);
    chk("R9", "done after drain", 64'(done_count), 64'(0));
  endtask

  task automatic t_isoc();
    cfg_kind = 2'b10; cfg_pkt_len = 14'd188;
    do_enq(32'h10, 188);
    chk_err("R10", 1, 0, 0);
    do_enq(32'h20, 377);
    chk_err("R10", 1, 0, 0);
    do_enq(32'h30, 376);
    chk_err("R10", 0, 0, 0);
    chk("R10", "isoc bd", 64'(slot_bd[25:13]), 64'd375);
    do_enq(32'h40, 564);
    chk_err("R10", 0, 0, 0);
    chk("R10", "both held", 64'(slot_rdy), 64'b11);
    drain(2);
    chk("R10", "drained", 64'(done_count), 64'(0));
  endtask

  task automatic t_sync();
    cfg_kind = 2'b11; cfg_bpf = 14'd4; cfg_fcnt = 3'd2;
    do_enq(32'h50, 24);
    chk_err("R11", 1, 0, 0);
    do_enq(32'h60, 8);
    chk_err("R11", 1, 0, 0);
    do_enq(32'h70, 48);
    chk_err("R11", 0, 0, 0);
    cfg_fcnt = 3'd0;
    do_enq(32'h80, 8);
    chk_err("R11", 0, 0, 0);
    chk("R11", "both held", 64'(slot_rdy), 64'b11);
    drain(2);
  endtask

  task automatic t_priority();
    cfg_kind = 2'b00;
    do_enq(32'h90, 10);
    do_enq(32'hA0, 20);
    chk("R13", "full", 64'(ready), 64'(0));
    do_enq(32'hB0, 0);
    chk_err("R13", 1, 0, 0);
    drain(2);
  endtask

  task automatic t_wrap();
    int errs;
    errs = 0;
    cfg_kind = 2'b00;
    for (int i = 0; i < 256; i++) begin
      do_enq(32'(i), 64);
      errs += int'(err_size | err_overflow | err_underflow);
      do_cmpl();
      do_svc();
      errs += int'(err_size | err_overflow | err_underflow);
      if (i == 254) chk("R12", "done at 255", 64'(done_count), 64'(255));
    end
    chk("R12", "no errors in loop", 64'(errs), 64'(0));
    chk("R12", "done wrapped", 64'(done_count), 64'(0));
    do_det(1);
    chk_err("R12", 0, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_fill();
    t_complete();
    t_detach();
    t_underflow();
    t_size_generic();
    t_isoc();
    t_sync();
    t_priority();
    t_wrap();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule